// File: doc/BRIEF.md
# Shuffle-Based Bitonic Merge Network

This block merges two ascending key lists of N entries each into a single ascending list of 2N entries. It is fully parallel and pipelined, and it accepts a new pair of lists on every clock. Inside the block, the second list is reversed. The joined lanes then form a bitonic sequence. That sequence passes through log2(2N) identical stages. Each stage applies the same perfect-shuffle wiring, which interleaves the lower half of the lanes with the upper half. A bank of N compare-exchange cells then works on neighbouring lane pairs at the same positions in every stage.

Each stage has one register level, so a result comes out log2(2N) cycles after its inputs were accepted. The valid flag travels with the data. The data registers load only on valid inputs, so the output keeps the last merged result until a newer one arrives. Keys are unsigned.

Top module: `bitonic_shuffle_merge`

## Requirements
- R1: When valid_o is high, keys_o holds keys in non-decreasing order from lane 0 (bits KEY_W-1:0) upward. Lane 0 holds the smallest key.
- R2: In keys_i, lanes 0..N-1 carry the first list and lanes N..2N-1 carry the second list. Lane k occupies bits k*KEY_W +: KEY_W. Both lists are ascending with rising lane index. The caller does not reverse either list.
- R3: valid_o rises exactly log2(2N) cycles after a cycle in which valid_i was sampled high (4 cycles with default parameters). Back-to-back inputs give back-to-back outputs.
- R4: The output is exactly the multiset union of both lists. Duplicate keys, including keys that appear in both lists, are all kept.
- R5: Keys are compared as unsigned numbers, so an all-ones key sorts above every key whose top bit is zero.
- R6: While no new result is leaving the pipeline, keys_o keeps the last merged result. keys_i has no effect in cycles where valid_i is low.
- R7: An active-low asynchronous reset forces valid_o to 0 and keys_o to all zeros at once, even in the middle of a stream.
- R8: Idle cycles between valid inputs do not disturb the results or the timing of the vectors around them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | keys_i holds a pair of lists to merge |
| keys_i | input | 2*N*KEY_W | Two ascending lists, first list in the low lanes |
| valid_o | output | 1 | keys_o holds a new merged result |
| keys_o | output | 2*N*KEY_W | Merged ascending list, smallest key in lane 0 |

## Verification
Two functions can fall in the same cycle:
- A finished result leaves the last stage while the first stage takes in a new vector and the middle stages move earlier vectors forward.
- In streams with gaps, a bubble passes through a stage and that stage holds its old data, while a neighbouring stage loads fresh data.

The bench provokes both cases by running the same vector table three times: back-to-back, with one idle cycle between vectors, and with two idle cycles. Junk is driven on keys_i in every idle cycle. Every output cycle is judged against a sorted union computed in the bench. In each run, cycles without a new result must show the previous result held unchanged on keys_o.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
  // Source lane feeding output position pos of a perfect shuffle on lanes lanes.
  function automatic int shuffle_src(input int pos, input int lanes);
    return ((pos % 2) == 0) ? (pos / 2) : (pos / 2 + lanes / 2);
  endfunction
endpackage

// File: rtl/bsm_cmp_exch.sv
module bsm_cmp_exch #(
  parameter int KEY_W = 8
) (
  input  logic [KEY_W-1:0] a_i,
  input  logic [KEY_W-1:0] b_i,
  output logic [KEY_W-1:0] lo_o,
  output logic [KEY_W-1:0] hi_o
);
  logic swap;
  // Equal keys do not swap.
  assign swap = a_i > b_i;
  assign lo_o = swap ? b_i : a_i;
  assign hi_o = swap ? a_i : b_i;
endmodule

// File: rtl/bsm_stage.sv
module bsm_stage
  import bsm_pkg::*;
#(
  parameter int LANES = 16,
  parameter int KEY_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic [LANES*KEY_W-1:0] keys_i,
  output logic                   valid_o,
  output logic [LANES*KEY_W-1:0] keys_o
);
  localparam int PAIRS = LANES / 2;
  localparam int VEC_W = LANES * KEY_W;
  localparam int SUM_W = KEY_W + $clog2(LANES);

  logic [VEC_W-1:0] shuf;
  logic [VEC_W-1:0] cx;
  logic [VEC_W-1:0] keys_q;
  logic             valid_q;

  for (genvar p = 0; p < LANES; p++) begin : g_shuf
    localparam int SRC = shuffle_src(p, LANES);
    assign shuf[p*KEY_W +: KEY_W] = keys_i[SRC*KEY_W +: KEY_W];
  end

  for (genvar j = 0; j < PAIRS; j++) begin : g_cx
    bsm_cmp_exch #(.KEY_W(KEY_W)) u_cx (
      .a_i  (shuf[(2*j)*KEY_W +: KEY_W]),
      .b_i  (shuf[(2*j+1)*KEY_W +: KEY_W]),
      .lo_o (cx[(2*j)*KEY_W +: KEY_W]),
      .hi_o (cx[(2*j+1)*KEY_W +: KEY_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      keys_q  <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) keys_q <= cx;
    end
  end

  assign valid_o = valid_q;
  assign keys_o  = keys_q;

  // Key sums on both sides of the stage, used only by the checks below.
  logic [SUM_W-1:0] sum_in, sum_out;
  always_comb begin
    sum_in  = '0;
    sum_out = '0;
    for (int i = 0; i < LANES; i++) begin
      sum_in  = sum_in  + SUM_W'(keys_i[i*KEY_W +: KEY_W]);
      sum_out = sum_out + SUM_W'(keys_q[i*KEY_W +: KEY_W]);
    end
  end

  assert_valid_follow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_q);
  assert_bubble_follow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_q);
  assert_idle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(keys_q));
  assert_sum_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> sum_out == $past(sum_in));
endmodule

// File: rtl/bitonic_shuffle_merge.sv
module bitonic_shuffle_merge #(
  parameter int N     = 8,
  parameter int KEY_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [2*N*KEY_W-1:0]     keys_i,
  output logic                     valid_o,
  output logic [2*N*KEY_W-1:0]     keys_o
);
  localparam int LANES  = 2 * N;
  localparam int STAGES = $clog2(LANES);
  localparam int VEC_W  = LANES * KEY_W;

  if ((1 << $clog2(N)) != N || N < 1) begin : g_bad_n
    $error("N must be a power of two");
  end

  logic [STAGES:0][VEC_W-1:0] stg_keys;
  logic [STAGES:0]            stg_valid;

  // Reverse the second list so that the joined lanes form a bitonic sequence.
  for (genvar j = 0; j < N; j++) begin : g_join
    assign stg_keys[0][j*KEY_W +: KEY_W]     = keys_i[j*KEY_W +: KEY_W];
    assign stg_keys[0][(N+j)*KEY_W +: KEY_W] = keys_i[(LANES-1-j)*KEY_W +: KEY_W];
  end
  assign stg_valid[0] = valid_i;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    bsm_stage #(.LANES(LANES), .KEY_W(KEY_W)) u_stage (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (stg_valid[s]),
      .keys_i  (stg_keys[s]),
      .valid_o (stg_valid[s+1]),
      .keys_o  (stg_keys[s+1])
    );
  end

  assign valid_o = stg_valid[STAGES];
  assign keys_o  = stg_keys[STAGES];

  for (genvar i = 0; i < LANES - 1; i++) begin : g_chk_order
    assert_out_sorted_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> keys_o[i*KEY_W +: KEY_W] <= keys_o[(i+1)*KEY_W +: KEY_W]);
  end
endmodule

// File: tb/bitonic_shuffle_merge_bench.sv
`timescale 1ns/1ps
module bitonic_shuffle_merge_bench;
  localparam int N   = 8;
  localparam int KW  = 8;
  localparam int LAT = 4;
  localparam int NV  = 8;
  localparam int VW  = 2*N*KW;

  // Ascending lists, lane 0 in the low byte.
  localparam logic [63:0] VEC_A [NV] = '{
    64'h0f0d0b0907050301, 64'h0807060504030201, 64'hfffefdfcfbfaf9f8,
    64'h5555555555555555, 64'h8080404020201010, 64'hffffffff00000000,
    64'h7f7e403f20100201, 64'hfe80010000000000 };
  localparam logic [63:0] VEC_B [NV] = '{
    64'h100e0c0a08060402, 64'h100f0e0d0c0b0a09, 64'h0706050403020100,
    64'h5555555555555555, 64'h9080704020100000, 64'hffff000000000000,
    64'hc0a0806040201008, 64'hff81800201000000 };

  logic clk, rst_n, valid_i, valid_o;
  logic [VW-1:0] keys_i, keys_o;
  int n_chk = 0, n_fail = 0;

  bitonic_shuffle_merge #(.N(N), .KEY_W(KW)) u_bitonic_shuffle_merge (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .keys_i(keys_i),
    .valid_o(valid_o), .keys_o(keys_o));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [VW-1:0] merged(input logic [63:0] a, input logic [63:0] b);
    logic [KW-1:0] k [2*N];
    logic [KW-1:0] t;
    logic [VW-1:0] r;
    for (int i = 0; i < N; i++) begin
      k[i]   = a[i*KW +: KW];
      k[i+N] = b[i*KW +: KW];
    end
    for (int i = 0; i < 2*N; i++)
      for (int j = 0; j < 2*N-1-i; j++)
        if (k[j] > k[j+1]) begin t = k[j]; k[j] = k[j+1]; k[j+1] = t; end
    for (int i = 0; i < 2*N; i++) r[i*KW +: KW] = k[i];
    return r;
  endfunction

  task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_stream(input int gap, input string tag);
    int period;
    int total;
    logic [VW-1:0] last;
    bit have;
    period = gap + 1;
    total  = NV*period + LAT + 3;
    have   = 1'b0;
    last   = '0;
    for (int c = 0; c < total; c++) begin
      int o;
      bit ev;
      int idx;
      logic [VW-1:0] exp;
      @(negedge clk);
      o  = c - LAT;
      ev = (o >= 0) && (o % period == 0) && (o / period < NV);
      check({"R3 ", tag}, VW'(valid_o), VW'(ev));
      if (ev) begin
        idx = o / period;
        exp = merged(VEC_A[idx], VEC_B[idx]);
        check({"R1 R2 ", tag}, keys_o, exp);
        if (idx == 3 || idx == 4) check("R4 duplicates", keys_o, exp);
        if (idx == 2 || idx == 5 || idx == 7) check("R5 unsigned", keys_o, exp);
        last = exp;
        have = 1'b1;
      end else if (have) begin
        check({"R6 hold ", tag}, keys_o, last);
      end
      if ((c % period == 0) && (c / period < NV)) begin
        valid_i = 1'b1;
        keys_i  = {VEC_B[c/period], VEC_A[c/period]};
      end else begin
        valid_i = 1'b0;
        keys_i  = {8{16'hdead}} ^ VW'(c);
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; valid_i = 1'b0; keys_i = '0;
    repeat (3) @(negedge clk);
    check("R7 reset valid", VW'(valid_o), '0);
    check("R7 reset keys", keys_o, '0);
    rst_n = 1'b1;

    run_stream(0, "back-to-back");
    run_stream(1, "R8 gap1");
    run_stream(2, "R8 gap2");

    // Reset in mid-stream.
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      valid_i = 1'b1;
      keys_i  = {VEC_B[c], VEC_A[c]};
    end
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R7 async valid", VW'(valid_o), '0);
    check("R7 async keys", keys_o, '0);
    valid_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (LAT + 1) @(negedge clk);
    check("R7 no stale valid", VW'(valid_o), '0);

    run_stream(0, "after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule